// File: doc/BRIEF.md
# Page Write-Protect and Address Checker

This block watches every bus cycle aimed at a physical memory of up to 1M words, split into 1024 pages of 1K words each. It holds two separate page protection bitmaps, one consulted for CPU-initiated cycles and one for DMA-initiated cycles. A memory write whose page bit is set in the bitmap of the requesting master type is flagged as a protection violation in the same cycle as the bus strobe. Reads are never flagged by page protection.

Two further checks share the same error path. A 64-bit presence map, one bit per 16K-word block, marks blocks as fitted or absent, and any memory access to an absent block is flagged. An inclusive I/O address window, loaded through the register port, marks I/O addresses as illegal. Each flag is the live detection ORed with a sticky copy that holds until the clear strobe. The address of the first violation since reset or since the last clear is captured and can be read back.

Software loads the bitmaps 16 bits at a time through a small register port: an index register picks the 16-bit word, and a write to a bitmap select stores the data word at that index.

Top module: `pwp_checker`

## Requirements
- R1: After reset all three flags are low, every CPU and DMA protection word reads 0x0000, every presence word reads 0xFFFF, the I/O low bound reads 0xFFFF, the I/O high bound reads 0x0000 and both fault registers read 0x0000.
- R2: When bus_strobe is high with bus_write=1, bus_io=0 and bus_dma=0, flag_prot is high in that same cycle if bit (bus_addr[19:10] mod 16) of CPU protection word (bus_addr[19:10] / 16) is set.
- R3: With bus_dma=1 the DMA protection bitmap is used instead of the CPU bitmap under the same rule; a bit set in only one bitmap flags only writes from that master type.
- R4: A memory cycle with bus_write=0 never raises flag_prot, even on a protected page.
- R5: An I/O cycle (bus_io=1) never raises flag_prot or flag_unimp.
- R6: A memory cycle (read or write) raises flag_unimp in the same cycle when bit (bus_addr[19:14] mod 16) of presence word (bus_addr[19:14] / 16) is clear.
- R7: An I/O cycle raises flag_io in the same cycle when io_low <= bus_addr[15:0] <= io_high (both bounds inclusive); memory cycles never raise flag_io.
- R8: Each flag stays high after the violating cycle until a clear strobe, regardless of later clean cycles.
- R9: err_clr drops the sticky flags so that they read low from the next cycle; a violation in the same cycle as err_clr sets its flag and is captured as the new fault address.
- R10: The address of the first violation after reset or clear is kept: select 6 reads bus_addr[15:0], select 7 reads bus_addr[19:16] in bits 3:0 and the sticky flags in bits 4 (prot), 5 (unimp), 6 (io); later violations do not replace it.
- R11: Register selects are 0 index (6 bits), 1 CPU word, 2 DMA word, 3 presence word (index bits 1:0), 4 I/O low, 5 I/O high, 6 and 7 fault (read only); each writable register reads back what was written, and writes to selects 6 and 7 have no effect.
- R12: With bus_strobe low no flag is raised whatever the other bus inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_sel |
| bus_strobe | input | 1 | Bus cycle valid |
| bus_addr | input | 20 | Physical word address (I/O address in bits 15:0) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| bus_dma | input | 1 | 1 = DMA master, 0 = CPU master |
| err_clr | input | 1 | Clears sticky flags and rearms capture |
| flag_prot | output | 1 | Write-protect violation |
| flag_unimp | output | 1 | Access to an absent memory block |
| flag_io | output | 1 | Illegal I/O address |

## Verification
Protected pages are hit with CPU and DMA writes, reads and I/O cycles, so that a wrong bitmap choice, a missing read exemption or a missing I/O exemption each give a different flag pattern. The I/O window is probed just below, at both ends and just above, which separates an inclusive compare from an exclusive one. Repeated violations and a clear that coincides with a new violation show whether the fault address keeps the first hit and whether clear or set wins.

// File: rtl/pwp_pkg.sv
// Shared types for the page write-protect checker.
// Assumes a 3-bit register select on the programming port.
package pwp_pkg;
    typedef enum logic [2:0] {
        SEL_INDEX    = 3'd0,
        SEL_CPU_WP   = 3'd1,
        SEL_DMA_WP   = 3'd2,
        SEL_PRESENT  = 3'd3,
        SEL_IO_LO    = 3'd4,
        SEL_IO_HI    = 3'd5,
        SEL_FAULT_LO = 3'd6,
        SEL_FAULT_HI = 3'd7
    } reg_sel_e;

    localparam int FLG_PROT  = 0;
    localparam int FLG_UNIMP = 1;
    localparam int FLG_IO    = 2;
    localparam int FLG_N     = 3;
endpackage

// File: rtl/pwp_bitmap.sv
// Bit map loaded a word at a time, with one word read port and one bit
// lookup port. Assumes NBITS is a multiple of WORD_W and a power of two.
module pwp_bitmap #(
    parameter int NBITS   = 1024,
    parameter int WORD_W  = 16,
    parameter bit RST_VAL = 1'b0,
    localparam int NWORDS = NBITS / WORD_W,
    localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1,
    localparam int BIT_W  = $clog2(NBITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_word,
    input  logic [BIT_W-1:0]  bit_idx,
    output logic              bit_out
);
    logic [NBITS-1:0] map_q;

    // Load the addressed word or return to the reset pattern.
    always_ff @(posedge clk) begin
        if (!rst_n)
            map_q <= {NBITS{RST_VAL}};
        else if (wr_en)
            map_q[idx*WORD_W +: WORD_W] <= wr_data;
    end

    // Word readback and per-bit lookup.
    always_comb begin
        rd_word = map_q[idx*WORD_W +: WORD_W];
        bit_out = map_q[bit_idx];
    end
endmodule

// File: rtl/pwp_io_range.sv
// Programmable inclusive illegal I/O window. Reset gives low > high,
// an empty window, so no I/O address is illegal until it is loaded.
module pwp_io_range #(
    parameter int IO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_lo,
    input  logic            we_hi,
    input  logic [IO_W-1:0] wr_data,
    input  logic [IO_W-1:0] io_addr,
    output logic [IO_W-1:0] lo_q,
    output logic [IO_W-1:0] hi_q,
    output logic            in_range
);
    // Hold the two window bounds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '1;
            hi_q <= '0;
        end else begin
            if (we_lo) lo_q <= wr_data;
            if (we_hi) hi_q <= wr_data;
        end
    end

    // Inclusive compare against both bounds.
    always_comb in_range = (io_addr >= lo_q) && (io_addr <= hi_q);

    // R7: an inverted window can never report a hit.
    a_r7_empty_window: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_q > hi_q) |-> !in_range);
endmodule

// File: rtl/pwp_err_capture.sv
// Sticky error flags and first-fault address capture. Assumes the hit
// vector is valid in the strobe cycle; clear and a new hit together
// leave the new hit set and captured.
module pwp_err_capture #(
    parameter int ADDR_W = 20,
    parameter int FLG_N  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [FLG_N-1:0]  hit,
    input  logic [ADDR_W-1:0] addr,
    output logic [FLG_N-1:0]  sticky_q,
    output logic [ADDR_W-1:0] fault_q
);
    logic any_hit;
    logic armed;

    // Capture is allowed when nothing is latched or a clear is in progress.
    always_comb begin
        any_hit = |hit;
        armed   = clr || (sticky_q == '0);
    end

    // Update sticky flags and the first-fault address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky_q <= '0;
            fault_q  <= '0;
        end else begin
            sticky_q <= clr ? hit : (sticky_q | hit);
            if (any_hit && armed)
                fault_q <= addr;
        end
    end

    // R8: a latched flag survives a cycle without clear.
    a_r8_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_q[0] && !clr) |=> sticky_q[0]);
    // R9: clear with no new hit empties every flag.
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !any_hit) |=> (sticky_q == '0));
    // R10: the captured address holds while a fault is latched.
    a_r10_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ((sticky_q != '0) && !clr) |=> $stable(fault_q));
    // R2: a detected hit leaves its flag latched.
    a_r2_hit_latched: assert property (@(posedge clk) disable iff (!rst_n)
        hit[0] |=> sticky_q[0]);
endmodule

// File: rtl/pwp_checker.sv
// Page write-protect and address checker. Holds CPU and DMA page
// protection maps, a block presence map and an illegal I/O window;
// flags violations in the strobe cycle and keeps them sticky.
// Assumes ADDR_W > WORD_W and page/block sizes that are powers of two.
module pwp_checker #(
    parameter int ADDR_W  = 20,
    parameter int PAGE_W  = 10,
    parameter int BLOCK_W = 14,
    parameter int WORD_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              bus_strobe,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_write,
    input  logic              bus_io,
    input  logic              bus_dma,
    input  logic              err_clr,
    output logic              flag_prot,
    output logic              flag_unimp,
    output logic              flag_io
);
    import pwp_pkg::*;

    localparam int NPAGES  = 1 << (ADDR_W - PAGE_W);
    localparam int NBLOCKS = 1 << (ADDR_W - BLOCK_W);
    localparam int PIDX_W  = $clog2(NPAGES / WORD_W);
    localparam int BIDX_W  = $clog2(NBLOCKS / WORD_W);
    localparam int HI_W    = ADDR_W - WORD_W;

    reg_sel_e            sel;
    logic [PIDX_W-1:0]   idx_q;
    logic [WORD_W-1:0]   prot_word [2];
    logic [1:0]          prot_bit;
    logic [WORD_W-1:0]   pres_word;
    logic                pres_bit;
    logic [WORD_W-1:0]   io_lo, io_hi;
    logic                io_hit;
    logic [FLG_N-1:0]    hit;
    logic [FLG_N-1:0]    sticky;
    logic [ADDR_W-1:0]   fault;

    assign sel = reg_sel_e'(reg_sel);

    // Word index register shared by all bitmaps.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (reg_we && sel == SEL_INDEX)
            idx_q <= reg_wdata[PIDX_W-1:0];
    end

    // One protection map per master type: 0 = CPU, 1 = DMA.
    for (genvar m = 0; m < 2; m++) begin : g_prot
        localparam reg_sel_e MSEL = (m == 0) ? SEL_CPU_WP : SEL_DMA_WP;
        pwp_bitmap #(.NBITS(NPAGES), .WORD_W(WORD_W), .RST_VAL(1'b0)) u_map (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (reg_we && sel == MSEL),
            .idx     (idx_q),
            .wr_data (reg_wdata),
            .rd_word (prot_word[m]),
            .bit_idx (bus_addr[ADDR_W-1:PAGE_W]),
            .bit_out (prot_bit[m])
        );
    end

    pwp_bitmap #(.NBITS(NBLOCKS), .WORD_W(WORD_W), .RST_VAL(1'b1)) u_present (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we && sel == SEL_PRESENT),
        .idx     (idx_q[BIDX_W-1:0]),
        .wr_data (reg_wdata),
        .rd_word (pres_word),
        .bit_idx (bus_addr[ADDR_W-1:BLOCK_W]),
        .bit_out (pres_bit)
    );

    pwp_io_range #(.IO_W(WORD_W)) u_io (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_lo    (reg_we && sel == SEL_IO_LO),
        .we_hi    (reg_we && sel == SEL_IO_HI),
        .wr_data  (reg_wdata),
        .io_addr  (bus_addr[WORD_W-1:0]),
        .lo_q     (io_lo),
        .hi_q     (io_hi),
        .in_range (io_hit)
    );

    // Classify the current bus cycle into the three violation kinds.
    always_comb begin
        hit            = '0;
        hit[FLG_PROT]  = bus_strobe && bus_write && !bus_io &&
                         (bus_dma ? prot_bit[1] : prot_bit[0]);
        hit[FLG_UNIMP] = bus_strobe && !bus_io && !pres_bit;
        hit[FLG_IO]    = bus_strobe && bus_io && io_hit;
    end

    pwp_err_capture #(.ADDR_W(ADDR_W), .FLG_N(FLG_N)) u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (err_clr),
        .hit      (hit),
        .addr     (bus_addr),
        .sticky_q (sticky),
        .fault_q  (fault)
    );

    // Flags show the live hit at once and the latched state afterwards.
    always_comb begin
        flag_prot  = sticky[FLG_PROT]  || hit[FLG_PROT];
        flag_unimp = sticky[FLG_UNIMP] || hit[FLG_UNIMP];
        flag_io    = sticky[FLG_IO]    || hit[FLG_IO];
    end

    // Register readback multiplexer.
    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_INDEX:    reg_rdata[PIDX_W-1:0] = idx_q;
            SEL_CPU_WP:   reg_rdata = prot_word[0];
            SEL_DMA_WP:   reg_rdata = prot_word[1];
            SEL_PRESENT:  reg_rdata = pres_word;
            SEL_IO_LO:    reg_rdata = io_lo;
            SEL_IO_HI:    reg_rdata = io_hi;
            SEL_FAULT_LO: reg_rdata = fault[WORD_W-1:0];
            SEL_FAULT_HI: begin
                reg_rdata[HI_W-1:0]       = fault[ADDR_W-1:WORD_W];
                reg_rdata[HI_W +: FLG_N]  = sticky;
            end
        endcase
    end

    // R4: a read strobe with nothing latched leaves flag_prot low.
    a_r4_read_free: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && !bus_write && !sticky[FLG_PROT]) |-> !flag_prot);
    // R12: with no strobe the outputs equal the latched state.
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_strobe |-> ({flag_io, flag_unimp, flag_prot} == sticky));
endmodule

// File: tb/pwp_checker_tb_top.sv
module pwp_checker_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        bus_strobe = 1'b0;
    logic [19:0] bus_addr = 20'h0;
    logic        bus_write = 1'b0;
    logic        bus_io = 1'b0;
    logic        bus_dma = 1'b0;
    logic        err_clr = 1'b0;
    logic        flag_prot, flag_unimp, flag_io;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string       req;
        int          kind;   // 0 flags {io,unimp,prot}, 1 reg_rdata
        logic [19:0] exp;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    pwp_checker dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_strobe(bus_strobe),
        .bus_addr(bus_addr), .bus_write(bus_write), .bus_io(bus_io),
        .bus_dma(bus_dma), .err_clr(err_clr), .flag_prot(flag_prot),
        .flag_unimp(flag_unimp), .flag_io(flag_io)
    );

    // Monitor: pop expected items and compare with the outputs.
    initial begin
        forever begin
            item_t it;
            logic [19:0] act;
            wait (sb_q.size() != 0);
            it = sb_q.pop_front();
            act = (it.kind == 0) ? {17'h0, flag_io, flag_unimp, flag_prot}
                                 : {4'h0, reg_rdata};
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
            end
        end
    end

    task automatic push(string req, int kind, logic [19:0] exp);
        item_t it;
        it.req = req; it.kind = kind; it.exp = exp;
        sb_q.push_back(it);
    endtask

    task automatic reg_wr(logic [2:0] s, logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_chk(logic [2:0] s, logic [15:0] e, string req);
        @(negedge clk);
        reg_sel = s;
        #1 push(req, 1, {4'h0, e});
    endtask

    task automatic bus(bit stb, logic [19:0] a, bit wr, bit io, bit dma,
                       logic [2:0] e, string req, bit clr = 1'b0);
        @(negedge clk);
        bus_strobe = stb; bus_addr = a; bus_write = wr; bus_io = io;
        bus_dma = dma; err_clr = clr;
        #1 push(req, 0, {17'h0, e});
        @(negedge clk);
        bus_strobe = 1'b0; err_clr = 1'b0;
    endtask

    task automatic flags_chk(logic [2:0] e, string req);
        @(negedge clk);
        #1 push(req, 0, {17'h0, e});
    endtask

    task automatic clear();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Driver.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        flags_chk(3'b000, "R1 flags");
        reg_chk(3'd1, 16'h0000, "R1 cpu word");
        reg_chk(3'd2, 16'h0000, "R1 dma word");
        reg_chk(3'd3, 16'hFFFF, "R1 presence");
        reg_chk(3'd4, 16'hFFFF, "R1 io low");
        reg_chk(3'd5, 16'h0000, "R1 io high");
        reg_chk(3'd7, 16'h0000, "R1 fault hi");
        // R11: readback and ignored fault writes
        reg_wr(3'd0, 16'h0000);
        reg_wr(3'd1, 16'h0020);
        reg_chk(3'd1, 16'h0020, "R11 cpu readback");
        reg_wr(3'd6, 16'h1234);
        reg_chk(3'd6, 16'h0000, "R11 fault write ignored");
        // R4, R2: page 5 protected for CPU
        bus(1, 20'h01400, 0, 0, 0, 3'b000, "R4 read protected page");
        bus(1, 20'h01400, 1, 0, 0, 3'b001, "R2 cpu write protected");
        flags_chk(3'b001, "R8 sticky after strobe");
        reg_chk(3'd6, 16'h1400, "R10 fault lo");
        reg_chk(3'd7, 16'h0010, "R10 fault hi");
        bus(1, 20'h01800, 1, 0, 0, 3'b001, "R8 clean write keeps flag");
        bus(1, 20'h01401, 1, 0, 0, 3'b001, "R2 second hit");
        reg_chk(3'd6, 16'h1400, "R10 first kept");
        clear();
        flags_chk(3'b000, "R9 cleared");
        // R3: DMA map separate
        bus(1, 20'h01400, 1, 0, 1, 3'b000, "R3 dma ignores cpu map");
        reg_wr(3'd0, 16'h0004);
        reg_chk(3'd0, 16'h0004, "R11 index readback");
        reg_wr(3'd2, 16'h0040);
        reg_chk(3'd2, 16'h0040, "R11 dma readback");
        reg_chk(3'd1, 16'h0000, "R11 cpu word untouched");
        bus(1, 20'h11800, 1, 0, 1, 3'b001, "R3 dma write protected");
        clear();
        bus(1, 20'h11800, 1, 0, 0, 3'b000, "R3 cpu ignores dma map");
        // R5: I/O write to protected-page address
        bus(1, 20'h01400, 1, 1, 0, 3'b000, "R5 io not prot checked");
        // R6: block 63 absent
        reg_wr(3'd0, 16'h0003);
        reg_wr(3'd3, 16'h7FFF);
        reg_chk(3'd3, 16'h7FFF, "R11 presence readback");
        bus(1, 20'hFC000, 0, 0, 0, 3'b010, "R6 read absent block");
        reg_chk(3'd6, 16'hC000, "R10 fault lo unimp");
        reg_chk(3'd7, 16'h002F, "R10 fault hi unimp");
        clear();
        bus(1, 20'hFC010, 1, 0, 1, 3'b010, "R6 write absent block");
        clear();
        bus(1, 20'hFC000, 0, 1, 0, 3'b000, "R5 io not unimp checked");
        // R7: inclusive I/O window
        reg_wr(3'd4, 16'h0100);
        reg_wr(3'd5, 16'h01FF);
        bus(1, 20'h000FF, 0, 1, 0, 3'b000, "R7 below window");
        bus(1, 20'h00100, 1, 1, 0, 3'b100, "R7 low bound");
        clear();
        bus(1, 20'h001FF, 0, 1, 0, 3'b100, "R7 high bound");
        clear();
        bus(1, 20'h00200, 0, 1, 0, 3'b000, "R7 above window");
        bus(1, 20'h00150, 1, 0, 0, 3'b000, "R7 memory not io checked");
        // R12: no strobe
        bus(0, 20'h01400, 1, 0, 0, 3'b000, "R12 strobe low");
        bus(0, 20'hFC000, 0, 1, 0, 3'b000, "R12 strobe low absent");
        // R9: clear together with new hit
        bus(1, 20'h01400, 1, 0, 0, 3'b001, "R2 set before clear");
        bus(1, 20'h00100, 1, 1, 0, 3'b101, "R9 hit during clear", 1'b1);
        flags_chk(3'b100, "R9 new hit wins");
        reg_chk(3'd6, 16'h0100, "R9 new fault captured");
        @(negedge clk);
        wait (sb_q.size() == 0);
        #1;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule